// File: doc/BRIEF.md
# Three-Wire Link Flush Sequencer

This block is the host end of the abort logic on a three-wire serial link. The remote device owns the clock line. The host owns the acknowledge line and a data line that it can only pull low (open drain). Clock and acknowledge together form a four-phase handshake:

| Phase change | Cause |
|---|---|
| P0 to P1 | the clock falls |
| P1 to P2 | the host lowers acknowledge |
| P2 to P3 | the clock rises |
| P3 to P0 | the host raises acknowledge |

When software wants to abandon a transfer, it pulses `start_i`. The block pulls data low, steps the handshake through a fixed number of full cycles, and then lets data go during a low-clock phase. After that it moves on its own into the receiving-flush role. In that role it keeps handshaking until the remote device shows data high in a high-clock phase, and it then returns the link to idle.

The receiving role can also be entered directly through `enter_flushee_i`, when the remote device is the one that flushes. Every wait on the clock line is bounded by a cycle limit. An overrun drops the sequence and raises a sticky error flag.

Top module: `tw_flush_seq`

## Requirements
- R1: Out of reset, `ack_o` is 1, and `dat_oe_o`, `busy_o`, `done_o` and `err_o` are all 0.
- R2: A `start_i` pulse while idle asserts `dat_oe_o` and `busy_o`. In each handshake, `ack_o` falls only after the clock line is seen low, and rises only after the clock line is seen high.
- R3: Exactly `HOLD_CYCLES` full handshake cycles (36 by default) complete while `dat_oe_o` is 1.
- R4: After those cycles, `dat_oe_o` is dropped in the next low-clock phase. In the same cycle `ack_o` falls, and the block is then in the receiving-flush role.
- R5: In the receiving-flush role, a low data line seen in a high-clock phase makes the block raise `ack_o` and run another handshake. A high data line seen there makes it raise `ack_o` and finish. For a remote device that shows N low samples, the block therefore finishes on high-clock phase N+1.
- R6: On a normal finish, `done_o` is high for exactly one cycle. In that same cycle `busy_o` is 0, `ack_o` is 1 and `dat_oe_o` is 0.
- R7: An `enter_flushee_i` pulse while idle never asserts `dat_oe_o`. The block waits for the clock line to be low, then lowers `ack_o`, then acts as in R5.
- R8: If any wait for a clock level lasts `TIMEOUT` cycles, the block does the following in the same cycle:
  - it sets `err_o`;
  - it returns to idle, with `ack_o` = 1 and `dat_oe_o` = 0;
  - it gives no `done_o` pulse.

  The error appears exactly `TIMEOUT` clock edges after the edge that entered the wait.
- R9: `err_o` stays at 1 until the next `start_i` or `enter_flushee_i` is accepted, which clears it.
- R10: The clock and data lines pass through a two-flop synchronizer. A change on the clock line takes effect on `ack_o` at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a flush as the flushing side (used when idle) |
| enter_flushee_i | input | 1 | Begin the receiving-flush role directly (used when idle) |
| lnk_clk_i | input | 1 | Link clock line, driven by the remote device |
| dat_i | input | 1 | Sensed level of the link data line |
| dat_oe_o | output | 1 | Pull the data line low; 0 releases it |
| ack_o | output | 1 | Link acknowledge line |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse on a normal return to idle |
| err_o | output | 1 | A clock wait timed out; sticky until the next start |

## Verification
A change on a link line reaches `ack_o` or `dat_oe_o` on the third rising edge after it: two edges in the synchronizer and one in the sequencer register. `done_o` rises on the same edge as the final `ack_o` rise. A timeout is due exactly `TIMEOUT` edges after the wait begins. The bench drives inputs just after a falling edge, and it samples the outputs at a later falling edge. Its remote-device model waits for each `ack_o` change before it moves the clock line again. The timing checks count those edges explicitly: R10 checks that `ack_o` has not moved after two edges and has moved after three, and R8 checks that `err_o` is clear after `TIMEOUT`-1 edges and set after `TIMEOUT`.

// File: rtl/tw_flush_seq.sv
module tw_flush_seq #(
  parameter int HOLD_CYCLES = 36,
  parameter int TIMEOUT     = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic enter_flushee_i,
  input  logic lnk_clk_i,
  input  logic dat_i,
  output logic dat_oe_o,
  output logic ack_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {IDLE, FL_LO, FL_HI, FL_REL, FE_LO, FE_HI} state_t;

  state_t                 state;
  logic [SYNC_STAGES-1:0] clk_sync, dat_sync;
  logic [CW-1:0]          cnt;
  logic [TW-1:0]          tmo;
  logic                   clk_s, dat_s, met, expired;

  assign clk_s   = clk_sync[SYNC_STAGES-1];
  assign dat_s   = dat_sync[SYNC_STAGES-1];
  assign busy_o  = (state != IDLE);
  assign expired = busy_o && !met && (tmo == TW'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sync <= '1;
      dat_sync <= '1;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], lnk_clk_i};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], dat_i};
    end

  always_comb
    case (state)
      FL_LO, FL_REL, FE_LO: met = !clk_s;
      FL_HI, FE_HI:         met = clk_s;
      default:              met = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= IDLE;
      ack_o    <= 1'b1;
      dat_oe_o <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      cnt      <= '0;
      tmo      <= '0;
    end else begin
      done_o <= 1'b0;
      tmo    <= (state == IDLE || met) ? '0 : tmo + TW'(1);
      case (state)
        IDLE:
          if (start_i) begin
            err_o    <= 1'b0;
            dat_oe_o <= 1'b1;
            cnt      <= '0;
            state    <= FL_LO;
          end else if (enter_flushee_i) begin
            err_o <= 1'b0;
            state <= FE_LO;
          end
        FL_LO:
          if (met) begin
            ack_o <= 1'b0;
            state <= FL_HI;
          end
        FL_HI:
          if (met) begin
            ack_o <= 1'b1;
            cnt   <= cnt + CW'(1);
            state <= (cnt == CW'(HOLD_CYCLES - 1)) ? FL_REL : FL_LO;
          end
        FL_REL:
          if (met) begin
            dat_oe_o <= 1'b0;
            ack_o    <= 1'b0;
            state    <= FE_HI;
          end
        FE_LO:
          if (met) begin
            ack_o <= 1'b0;
            state <= FE_HI;
          end
        FE_HI:
          if (met) begin
            ack_o <= 1'b1;
            if (dat_s) begin
              done_o <= 1'b1;
              state  <= IDLE;
            end else begin
              state <= FE_LO;
            end
          end
        default: state <= IDLE;
      endcase
      if (expired) begin
        state    <= IDLE;
        ack_o    <= 1'b1;
        dat_oe_o <= 1'b0;
        err_o    <= 1'b1;
      end
    end

  p_oe_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe_o |-> busy_o);
  p_ack_fall_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(clk_s));
  p_ack_rise_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) && !err_o |-> $past(clk_s));
  p_release_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe_o) && !err_o |-> !$past(clk_s) && !ack_o);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && ack_o && !dat_oe_o);
  p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o && ack_o && !dat_oe_o && !done_o);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> $past(start_i || enter_flushee_i));
endmodule

// File: tb/tw_flush_seq_test.sv
module tw_flush_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 36;
  localparam int TO   = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, enter_flushee_i = 1'b0;
  logic lnk_clk = 1'b1, rem_dat = 1'b1;
  logic dat_oe_o, ack_o, busy_o, done_o, err_o;
  wire  dat_line = dat_oe_o ? 1'b0 : rem_dat;

  int checks = 0, errors = 0, cyc = 0;
  int n_done = 0, n_oe = 0, v_rel = 0, v_ack = 0;
  logic prev_oe = 1'b0, prev_ack = 1'b1;

  tw_flush_seq #(.HOLD_CYCLES(HOLD), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .enter_flushee_i(enter_flushee_i),
    .lnk_clk_i(lnk_clk), .dat_i(dat_line), .dat_oe_o(dat_oe_o), .ack_o(ack_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) n_done++;
      if (dat_oe_o) n_oe++;
      if (prev_oe && !dat_oe_o && lnk_clk) v_rel++;
      if (prev_ack && !ack_o && lnk_clk) v_ack++;
    end
    prev_oe  = dat_oe_o;
    prev_ack = ack_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int exp_held(bit flusher);
    return flusher ? HOLD : 0;
  endfunction
  function automatic int exp_p3(int low_n);
    return low_n + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_ack(logic v, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (ack_o == v) begin ok = 1'b1; return; end
      tick();
    end
  endtask

  task automatic remote(int low_n, output int held, output int p3s, output bit ok);
    int fe_idx = 0;
    bit in_fe;
    held = 0; p3s = 0; rem_dat = 1'b1;
    for (int k = 0; k < 200; k++) begin
      tick($urandom % 6);
      lnk_clk = 1'b0;
      wait_ack(1'b0, ok);
      if (!ok) return;
      tick($urandom % 6);
      in_fe = !dat_oe_o;
      if (in_fe) begin
        rem_dat = (fe_idx < low_n) ? 1'b0 : 1'b1;
        fe_idx++;
      end else held++;
      lnk_clk = 1'b1;
      if (in_fe) p3s++;
      wait_ack(1'b1, ok);
      if (!ok) return;
      if (in_fe && rem_dat) return;
    end
    ok = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ack", ack_o, 1);
    chk("R1 oe", dat_oe_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", n_done, 0);
    chk("R1 err", err_o, 0);

    // R10 synchronizer latency, then R8 timeout while waiting for high
    start_i = 1'b1; tick(); start_i = 1'b0;
    chk("R2 oe after start", dat_oe_o, 1);
    chk("R2 busy after start", busy_o, 1);
    lnk_clk = 1'b0;
    tick(2);
    chk("R10 ack held two edges", ack_o, 1);
    tick();
    chk("R10 ack falls third edge", ack_o, 0);
    tick(TO + 2);
    chk("R8 err after wait-high stall", err_o, 1);
    chk("R8 ack high after timeout", ack_o, 1);
    chk("R8 oe released after timeout", dat_oe_o, 0);
    chk("R8 idle after timeout", busy_o, 0);
    chk("R8 no done", n_done, 0);
    lnk_clk = 1'b1;
    tick(30);
    chk("R9 err sticky", err_o, 1);

    // R8 exact timeout edge with clock stuck high; R9 clear on start
    start_i = 1'b1; tick(); start_i = 1'b0;
    chk("R9 err cleared by start", err_o, 0);
    tick(TO - 1);
    chk("R8 no err at TO-1", err_o, 0);
    chk("R8 still busy at TO-1", busy_o, 1);
    tick();
    chk("R8 err at TO", err_o, 1);

    // R8 timeout in receiving role, R9 cleared by entry
    enter_flushee_i = 1'b1; tick(); enter_flushee_i = 1'b0;
    chk("R9 err cleared by flushee entry", err_o, 0);
    chk("R7 no oe on entry", dat_oe_o, 0);
    tick(TO + 2);
    chk("R8 flushee timeout err", err_o, 1);
    chk("R8 flushee timeout ack", ack_o, 1);
    chk("R8 flushee no done", n_done, 0);

    // random and directed full sequences
    for (int it = 0; it < 10; it++) begin
      bit fl = (it < 2) ? 1'b1 : bit'($urandom % 2);
      int low_n = (it == 0) ? 0 : (it == 1) ? 4 : int'($urandom % 5);
      int held, p3s, d0;
      bit ok;
      d0 = n_done; n_oe = 0; v_rel = 0; v_ack = 0;
      if (fl) start_i = 1'b1; else enter_flushee_i = 1'b1;
      tick();
      start_i = 1'b0; enter_flushee_i = 1'b0;
      chk(fl ? "R2 oe on start" : "R7 oe on entry", dat_oe_o, fl);
      remote(low_n, held, p3s, ok);
      chk("R5 remote completed", ok, 1);
      chk(fl ? "R3 held cycles" : "R7 no held cycles", held, exp_held(fl));
      chk("R5 high-clock samples", p3s, exp_p3(low_n));
      chk("R6 one done pulse", n_done - d0, 1);
      chk("R6 idle at done", busy_o, 0);
      chk("R6 ack high", ack_o, 1);
      chk("R4 release in low phase", v_rel, 0);
      chk("R2 ack falls only in low phase", v_ack, 0);
      chk("R9 no err", err_o, 0);
      if (!fl) chk("R7 oe never driven", n_oe, 0);
      tick(3);
      chk("R6 done stays single", n_done - d0, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule